// File: doc/BRIEF.md
# Power and Sleep Domain Sequencer

This block controls, for a small set of power domains and the modules within them, the clock and reset state of each module and the on/off state of each domain. Software sets a wanted state for each module and a wanted power level for each domain through a 32-bit register port. It then starts a transition for one or more domains through a command register. The block takes the domain through the transition, shows a busy flag for each domain, and drives a clock-enable and an active-low reset line for each module.

A domain that is switched on from off follows a two-phase handshake. The block raises a power-switch request and waits for the switch acknowledge, which it synchronizes into a pending flag. Software then confirms with a good bit, and only after that does the module sequencing finish. A domain that is already on goes straight to module sequencing. Module state changes take effect only when their domain's command completes.

Module m belongs to domain m mod N_DOM. Registers are 32-bit words on 4-byte addresses. The address bits [11:8] select a region and bits [7:2] select an index within it.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset every module is in the SwRstDisable state. All clock enables, module reset lines (mod_rst_n), power requests, busy flags and domain status bits read 0, and every module control register reads 0x100.
- R2: The register map is as follows. The command is at 0x000, busy at 0x004 and pending at 0x008, with bit d standing for domain d. Domain control is at 0x100+4d, domain status at 0x200+4d, module control at 0x300+4m and module status at 0x400+4m. Module control keeps only its state bits [1:0], the local-reset bit 8 and the force bit 31. An index past the last module or domain, and any other address, reads 0.
- R3: The state codes are SwRstDisable=0, SyncReset=1, Disable=2 and Enable=3. A module's clock enable is 1 in SyncReset and Enable. Its reset line is released (1) only in Disable and Enable. Module status holds the state in bits [1:0] and sets bit 12 while the clock is enabled.
- R4: A command for an idle domain that stays at its power level holds busy for exactly TRANS_CYC cycles. Module states change only at the end of that window, where they take the requested state.
- R5: Module control bit 8 is an active-low local reset. Clearing it forces the module's reset line to 0 at once, without a command.
- R6: A command to an off domain whose control bit 0 is 1 raises the domain's power request. The transition waits for both the pending flag and the good bit (control bit 8), then runs TRANS_CYC more cycles. The domain status bit 0 becomes 1 and the good bit clears itself.
- R7: The pending flag follows the domain's power-switch acknowledge through two flip-flops.
- R8: In a domain that is off, a clocked state (SyncReset or Enable) is not applied unless the force bit is set. Non-clocked states are always applied.
- R9: A command bit for a domain that is already busy is ignored. The running transition keeps its original end cycle.
- R10: A command to an on domain whose control bit 0 is 0 ends with the domain off, so status bit 0 and the power request both read 0.
- R11: A command affects only the modules of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| pwr_ack | input | N_DOM | Power-switch acknowledge per domain (asynchronous) |
| pwr_req | output | N_DOM | Power-switch request per domain |
| mod_clk_en | output | N_MOD | Clock enable per module |
| mod_rst_n | output | N_MOD | Active-low reset per module |

## Verification
A command to an idle, powered domain sets busy in the edge that accepts the write, and the new module state and the falling busy flag appear TRANS_CYC edges later. On the power-up path the good-bit write adds one edge, which gives TRANS_CYC+1. A busy-ignored command leaves the original end edge in place. The acknowledge shows up in the pending flag two edges after it changes, while local reset and register readback take effect on the output in the same cycle. The bench writes on one edge and samples every result at a falling edge. It counts the falling edges until busy clears and compares that count with the exact value for each path.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef enum logic [1:0] {
      MS_SWRST_OFF = 2'd0,
      MS_SYNC_RST  = 2'd1,
      MS_GATED     = 2'd2,
      MS_RUN       = 2'd3
   } mod_state_e;

   localparam logic [3:0] RG_GLOBAL = 4'h0;
   localparam logic [3:0] RG_DCTL   = 4'h1;
   localparam logic [3:0] RG_DSTAT  = 4'h2;
   localparam logic [3:0] RG_MCTL   = 4'h3;
   localparam logic [3:0] RG_MSTAT  = 4'h4;

   localparam logic [5:0] GI_CMD  = 6'd0;
   localparam logic [5:0] GI_BUSY = 6'd1;
   localparam logic [5:0] GI_PEND = 6'd2;

   localparam int MC_FORCE_BIT = 31;
   localparam int MC_LRST_BIT  = 8;
   localparam int DC_GOOD_BIT  = 8;
   localparam int MS_CLK_BIT   = 12;

   function automatic logic is_clocked(input logic [1:0] st);
      return (st == MS_SYNC_RST) || (st == MS_RUN);
   endfunction

   function automatic logic is_released(input logic [1:0] st);
      return (st == MS_GATED) || (st == MS_RUN);
   endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq #(
   parameter int TRANS_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic want_on,
   input  logic good,
   input  logic pend,
   output logic busy,
   output logic apply,
   output logic pwr_done,
   output logic dom_on,
   output logic pwr_req
);
   localparam int CW = (TRANS_CYC > 1) ? $clog2(TRANS_CYC) : 1;

   typedef enum logic [1:0] {DS_IDLE, DS_PWRUP, DS_MODS} dseq_e;

   dseq_e         st;
   logic [CW-1:0] cnt;

   assign busy     = (st != DS_IDLE);
   assign apply    = (st == DS_MODS) && (cnt == CW'(TRANS_CYC - 1));
   assign pwr_done = (st == DS_PWRUP) && pend && good;
   assign pwr_req  = dom_on || (st == DS_PWRUP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= DS_IDLE;
         cnt    <= '0;
         dom_on <= 1'b0;
      end else begin
         case (st)
            DS_IDLE: if (start) begin
               cnt <= '0;
               st  <= (!dom_on && want_on) ? DS_PWRUP : DS_MODS;
            end
            DS_PWRUP: if (pwr_done) begin
               cnt    <= '0;
               dom_on <= 1'b1;
               st     <= DS_MODS;
            end
            DS_MODS: if (apply) begin
               st <= DS_IDLE;
               if (!want_on) dom_on <= 1'b0;
            end else begin
               cnt <= cnt + 1'b1;
            end
            default: st <= DS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pwr_mod_unit.sv
module pwr_mod_unit
   import pwr_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       apply,
   input  logic       dom_ok,
   input  logic [1:0] next_st,
   input  logic       force_en,
   input  logic       lrst_n,
   output logic [1:0] cur_st,
   output logic       clk_en,
   output logic       rst_out_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_st <= MS_SWRST_OFF;
      else if (apply && (force_en || dom_ok || !is_clocked(next_st)))
         cur_st <= next_st;
   end

   assign clk_en    = is_clocked(cur_st);
   assign rst_out_n = is_released(cur_st) && lrst_n;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
   import pwr_seq_pkg::*;
#(
   parameter int N_MOD       = 4,
   parameter int N_DOM       = 2,
   parameter int TRANS_CYC   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [11:0]      reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic [N_DOM-1:0] pwr_ack,
   output logic [N_DOM-1:0] pwr_req,
   output logic [N_MOD-1:0] mod_clk_en,
   output logic [N_MOD-1:0] mod_rst_n
);
   if (N_MOD < 1 || N_MOD > 64) $error("N_MOD must be 1..64");
   if (N_DOM < 1 || N_DOM > 32) $error("N_DOM must be 1..32");
   if (TRANS_CYC < 1)           $error("TRANS_CYC must be at least 1");
   if (SYNC_STAGES == 1)        $error("SYNC_STAGES must be 0 or >= 2");

   logic [3:0] region;
   logic [5:0] idx;
   logic       aligned;
   assign region  = reg_addr[11:8];
   assign idx     = reg_addr[7:2];
   assign aligned = (reg_addr[1:0] == 2'b00);

   logic [N_DOM-1:0] busy_w, apply_w, done_w, dom_on_w, pend_w, start_w;
   logic [N_DOM-1:0] dctl_on, dctl_good;
   logic [1:0]       mctl_next  [N_MOD];
   logic [N_MOD-1:0] mctl_lrst, mctl_force;
   logic [1:0]       mstate     [N_MOD];

   for (genvar d = 0; d < N_DOM; d++) begin : g_dom
      assign start_w[d] = reg_wr && aligned && region == RG_GLOBAL &&
                          idx == GI_CMD && reg_wdata[d] && !busy_w[d];

      if (SYNC_STAGES == 0) begin : g_nosync
         assign pend_w[d] = pwr_ack[d];
      end else begin : g_sync
         pwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(pwr_ack[d]), .q(pend_w[d]));
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dctl_on[d]   <= 1'b0;
            dctl_good[d] <= 1'b0;
         end else if (reg_wr && aligned && region == RG_DCTL && idx == 6'(d)) begin
            dctl_on[d]   <= reg_wdata[0];
            dctl_good[d] <= reg_wdata[DC_GOOD_BIT];
         end else if (done_w[d]) begin
            dctl_good[d] <= 1'b0;
         end
      end

      pwr_dom_seq #(.TRANS_CYC(TRANS_CYC)) u_seq (
         .clk(clk), .rst_n(rst_n), .start(start_w[d]), .want_on(dctl_on[d]),
         .good(dctl_good[d]), .pend(pend_w[d]), .busy(busy_w[d]),
         .apply(apply_w[d]), .pwr_done(done_w[d]), .dom_on(dom_on_w[d]),
         .pwr_req(pwr_req[d]));
   end

   for (genvar m = 0; m < N_MOD; m++) begin : g_mod
      localparam int DOM = m % N_DOM;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mctl_next[m]  <= MS_SWRST_OFF;
            mctl_lrst[m]  <= 1'b1;
            mctl_force[m] <= 1'b0;
         end else if (reg_wr && aligned && region == RG_MCTL && idx == 6'(m)) begin
            mctl_next[m]  <= reg_wdata[1:0];
            mctl_lrst[m]  <= reg_wdata[MC_LRST_BIT];
            mctl_force[m] <= reg_wdata[MC_FORCE_BIT];
         end
      end

      pwr_mod_unit u_mod (
         .clk(clk), .rst_n(rst_n), .apply(apply_w[DOM]),
         .dom_ok(dom_on_w[DOM] && dctl_on[DOM]), .next_st(mctl_next[m]),
         .force_en(mctl_force[m]), .lrst_n(mctl_lrst[m]), .cur_st(mstate[m]),
         .clk_en(mod_clk_en[m]), .rst_out_n(mod_rst_n[m]));
   end

   always_comb begin
      reg_rdata = '0;
      if (aligned) begin
         case (region)
            RG_GLOBAL: begin
               if (idx == GI_BUSY) reg_rdata[N_DOM-1:0] = busy_w;
               if (idx == GI_PEND) reg_rdata[N_DOM-1:0] = pend_w;
            end
            RG_DCTL: for (int d = 0; d < N_DOM; d++) begin
               if (idx == 6'(d)) begin
                  reg_rdata[0]           = dctl_on[d];
                  reg_rdata[DC_GOOD_BIT] = dctl_good[d];
               end
            end
            RG_DSTAT: for (int d = 0; d < N_DOM; d++) begin
               if (idx == 6'(d)) reg_rdata[0] = dom_on_w[d];
            end
            RG_MCTL: for (int m = 0; m < N_MOD; m++) begin
               if (idx == 6'(m)) begin
                  reg_rdata[1:0]          = mctl_next[m];
                  reg_rdata[MC_LRST_BIT]  = mctl_lrst[m];
                  reg_rdata[MC_FORCE_BIT] = mctl_force[m];
               end
            end
            RG_MSTAT: for (int m = 0; m < N_MOD; m++) begin
               if (idx == 6'(m)) begin
                  reg_rdata[1:0]        = mstate[m];
                  reg_rdata[MS_CLK_BIT] = is_clocked(mstate[m]);
               end
            end
            default: reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
   parameter int N_MOD = 4,
   parameter int N_DOM = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [11:0]      reg_addr,
   input logic [31:0]      reg_wdata,
   input logic [N_DOM-1:0] busy,
   input logic [N_DOM-1:0] pwr_req,
   input logic [N_MOD-1:0] mod_clk_en
);
   for (genvar d = 0; d < N_DOM; d++) begin : g_d
      AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(busy[d]) |-> $past(reg_wr && reg_addr == 12'h000 && reg_wdata[d])); // R4
      AST_REQ_RISE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pwr_req[d]) |-> busy[d]); // R6
      AST_REQ_FALL_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pwr_req[d]) |-> $past(busy[d])); // R10
   end
   for (genvar m = 0; m < N_MOD; m++) begin : g_m
      localparam int DOM = m % N_DOM;
      AST_CLK_MOVES_IN_OWN_DOMAIN: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(mod_clk_en[m]) |-> $past(busy[DOM])); // R11
   end
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.N_MOD(N_MOD), .N_DOM(N_DOM)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .busy(busy_w), .pwr_req(pwr_req),
   .mod_clk_en(mod_clk_en));

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
   localparam int N_MOD = 4;
   localparam int N_DOM = 2;
   localparam int T     = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic [11:0]      reg_addr = '0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic [N_DOM-1:0] pwr_ack = '0;
   logic [N_DOM-1:0] pwr_req;
   logic [N_MOD-1:0] mod_clk_en;
   logic [N_MOD-1:0] mod_rst_n;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pwr_seq_ctrl #(.N_MOD(N_MOD), .N_DOM(N_DOM), .TRANS_CYC(T), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_ack(pwr_ack),
      .pwr_req(pwr_req), .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n));

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] v);
      @(negedge clk);
      reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic rdchk(input logic [11:0] a, input logic [31:0] exp, input string tag);
      logic [31:0] v;
      rd(a, v);
      chk(v, exp, tag);
   endtask

   // falling edges until busy for domain d reads 0
   task automatic idle_after(input int d, input int exp, input string tag);
      int n = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         reg_addr = 12'h004;
         #1 n++;
         if (!reg_rdata[d]) break;
      end
      chk(32'(n), 32'(exp), tag);
   endtask

   task automatic finish_sim;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_sim();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      #1;
      chk(32'(mod_clk_en), 32'h0, "R1 clk_en");
      chk(32'(mod_rst_n), 32'h0, "R1 rst_n");
      chk(32'(pwr_req), 32'h0, "R1 pwr_req");
      rdchk(12'h004, 32'h0, "R1 busy");
      rdchk(12'h200, 32'h0, "R1 dom status");
      for (int m = 0; m < N_MOD; m++) begin
         rdchk(12'h400 + 12'(4*m), 32'h0, "R1 mod status");
         rdchk(12'h300 + 12'(4*m), 32'h100, "R1 mod ctrl");
      end

      // R2 field masking and unmapped reads
      wr(12'h304, 32'hFFFF_FFFF);
      rdchk(12'h304, 32'h8000_0103, "R2 mctl readback");
      wr(12'h304, 32'h0000_0100);
      rdchk(12'h3F0, 32'h0, "R2 index past last module");
      rdchk(12'h0FC, 32'h0, "R2 unmapped global");

      // R6/R7 power-up of domain 0
      wr(12'h300, 32'h103);
      wr(12'h308, 32'h101);
      wr(12'h100, 32'h1);
      wr(12'h000, 32'h1);
      chk(32'(pwr_req[0]), 32'h1, "R6 request raised");
      repeat (5) @(negedge clk);
      rdchk(12'h004, 32'h1, "R6 waits for ack");
      @(negedge clk) pwr_ack[0] = 1'b1;
      @(negedge clk); reg_addr = 12'h008;
      #1 chk(reg_rdata & 32'h1, 32'h0, "R7 pend after one edge");
      @(negedge clk);
      #1 chk(reg_rdata & 32'h1, 32'h1, "R7 pend after two edges");
      rdchk(12'h004, 32'h1, "R6 waits for good");
      wr(12'h100, 32'h101);
      idle_after(0, T + 2, "R6 power-up latency");
      rdchk(12'h400, 32'h1003, "R6 mod0 enable");
      rdchk(12'h408, 32'h1001, "R3 mod2 syncreset");
      rdchk(12'h404, 32'h0, "R11 mod1 untouched");
      chk(32'(mod_clk_en), 32'h5, "R3 clk_en");
      chk(32'(mod_rst_n), 32'h1, "R3 rst_n");
      rdchk(12'h200, 32'h1, "R6 domain on");
      rdchk(12'h100, 32'h1, "R6 good self-clears");

      // R8 dependency in off domain 1
      wr(12'h304, 32'h103);
      wr(12'h30C, 32'h102);
      rdchk(12'h40C, 32'h0, "R4 no change before command");
      wr(12'h000, 32'h2);
      idle_after(1, T + 1, "R4 busy length");
      rdchk(12'h404, 32'h0, "R8 clocked blocked");
      rdchk(12'h40C, 32'h2, "R8 gated applied");
      chk(32'(pwr_req[1]), 32'h0, "R8 no power request");
      chk(32'(mod_rst_n[3]), 32'h1, "R3 gated released");
      wr(12'h304, 32'h8000_0103);
      wr(12'h000, 32'h2);
      idle_after(1, T + 1, "R8 forced busy length");
      rdchk(12'h404, 32'h1003, "R8 forced enable");
      chk(32'(mod_clk_en), 32'h7, "R8 clk_en");

      // R5 local reset
      wr(12'h300, 32'h003);
      chk(32'(mod_rst_n[0]), 32'h0, "R5 local reset asserted");
      chk(32'(mod_clk_en[0]), 32'h1, "R5 clock kept");
      rdchk(12'h400, 32'h1003, "R5 state unchanged");
      wr(12'h300, 32'h103);
      chk(32'(mod_rst_n[0]), 32'h1, "R5 local reset released");

      // R3 sweep of all states on module 0
      for (int s = 0; s < 4; s++) begin
         logic ce, rn;
         ce = (s == 1) || (s == 3);
         rn = (s >= 2);
         wr(12'h300, 32'h100 | 32'(s));
         wr(12'h000, 32'h1);
         idle_after(0, T + 1, "R4 sweep busy");
         chk(32'(mod_clk_en[0]), 32'(ce), "R3 sweep clk_en");
         chk(32'(mod_rst_n[0]), 32'(rn), "R3 sweep rst_n");
         rdchk(12'h400, 32'(s) | (32'(ce) << 12), "R3 sweep status");
      end

      // R9 command while busy is ignored
      wr(12'h000, 32'h1);
      wr(12'h300, 32'h102);
      wr(12'h000, 32'h1);
      idle_after(0, T - 1, "R9 original end kept");
      rdchk(12'h400, 32'h2, "R9 live state applied");

      // R10 power-down of domain 0, R11 domain 1 untouched
      wr(12'h308, 32'h102);
      wr(12'h304, 32'h100);
      wr(12'h100, 32'h0);
      wr(12'h000, 32'h1);
      idle_after(0, T + 1, "R10 busy length");
      rdchk(12'h200, 32'h0, "R10 domain off");
      chk(32'(pwr_req), 32'h0, "R10 request dropped");
      rdchk(12'h408, 32'h2, "R10 mod2 gated");
      rdchk(12'h404, 32'h1003, "R11 mod1 kept");
      pwr_ack[0] = 1'b0;

      finish_sim();
   end
endmodule